// File: doc/BRIEF.md
# Locality-Arbitrated Byte FIFO Command Interface

This block is the device end of a memory-mapped command channel for a security coprocessor. A host first claims locality 0 through an access register. It then streams a command one byte at a time into a data port, watching a status register. That register shows whether more bytes are still wanted and how much room is left (the burst count). When the command is complete, the host sets the go bit. The block then passes the stored command to a back-end processing stub and collects the response bytes that the stub returns.

The host drains the response through the same data port. The burst count now reports how many response bytes are left. A retry bit starts the read-out again from the first byte. Writing the command-ready bit outside the receive phase abandons the transaction and returns the block to an empty receive phase. The expected command length comes from the big-endian length field in the command header (bytes 2 to 5), and the data-expected flag follows it.

The register bus is a single port with combinational read data and write side effects at the clock edge. Every access is either a byte access or a 32-bit access.

Top module: `lfci_core`

## Requirements
- R1: The access register (offset 0x00) reads 0x80 after reset: bit 7 (valid) is set and bit 5 (active locality) is clear. A byte write with bit 1 set grants locality 0, and the register then reads 0xA0. A write with bit 1 clear and bit 5 set releases the locality.
- R2: While the locality is not held, writes to the status register (0x18) and to the data port (0x24) have no effect, and reads of either return 0xFF in every byte lane.
- R3: The status byte (bits 7:0 at 0x18) has this layout: bit 7 valid (always 1 while the locality is held), bit 6 command-ready (set in the receive phase), bit 4 data-available, bit 3 data-expected. The go, retry and reserved bits read as 0.
- R4: Status bits 23:8 hold a 16-bit burst count, saturated at 0xFFFF. It equals DEPTH minus the stored command bytes in the receive phase, 0 while the back-end is executing, and the unread response bytes in the response phase. Byte reads at 0x19 and 0x1A return its low and high byte and change nothing.
- R5: Each write of wdata[7:0] to 0x24 in the receive phase appends one command byte. Data-expected stays high until max(6, L) bytes are stored, where L is the big-endian header length field (bytes 2 to 5) capped at DEPTH. A byte written while data-expected is low is dropped.
- R6: Writing status bit 5 (go) in the receive phase, with data-expected low and at least one byte stored, raises be_go for exactly one cycle and sets be_len to the stored byte count. A go written while data-expected is high is ignored.
- R7: While the back-end is executing, each be_rsp_valid cycle stores be_rsp_byte, and be_rsp_last ends the execution. Data-available is then high. Each read of 0x24 returns the next response byte in order, and data-available falls after the last byte is read.
- R8: Writing status bit 1 (retry) in the response phase rewinds the response read point to byte 0.
- R9: Writing status bit 6 (command-ready) while executing or in the response phase empties both buffers and returns to the receive phase. Back-end response bytes that arrive outside the executing phase are ignored.
- R10: The interrupt-enable register at 0x08 (global enable at bit 31) is a 32-bit read/write word that resets to 0. The capability register at 0x14 reads CAP_VALUE, which is never all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = byte access, 0 = 32-bit access |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 32 | Read data, byte reads in bits 7:0 |
| be_go | output | 1 | One-cycle command launch to the back-end |
| be_len | output | CNT_W (11) | Launched command length in bytes |
| be_cmd_idx | input | IDX_W (10) | Back-end command byte index |
| be_cmd_byte | output | 8 | Command byte at be_cmd_idx |
| be_rsp_valid | input | 1 | Response byte strobe |
| be_rsp_byte | input | 8 | Response byte |
| be_rsp_last | input | 1 | Marks the final response byte |

## Verification
The hardest state to reach is where the header length field and the buffer depth disagree. One case is a declared length below the six-byte header. The other is a declared length beyond the buffer, where data-expected has to clear at exactly DEPTH bytes and any further bytes must be dropped. The stimulus covers both: it sends a command with length field 3, and another declaring 2000 bytes followed by 1030 data-port writes, then checks the burst count, the flags and be_len. It also aborts while the back-end is still busy and afterwards feeds a late response byte, to show that the stale byte is dropped.

// File: rtl/lfci_pkg.sv
package lfci_pkg;

    localparam logic [9:0] WA_ACCESS = 10'h000;
    localparam logic [9:0] WA_IRQ_EN = 10'h002;
    localparam logic [9:0] WA_CAPS   = 10'h005;
    localparam logic [9:0] WA_STATUS = 10'h006;
    localparam logic [9:0] WA_DATA   = 10'h009;

    localparam int ACC_REQ_BIT    = 1;
    localparam int ACC_ACTIVE_BIT = 5;

    localparam int STS_CMDRDY_BIT = 6;
    localparam int STS_GO_BIT     = 5;
    localparam int STS_RETRY_BIT  = 1;

    localparam int HDR_BYTES = 6;

    typedef enum logic [1:0] {
        ST_RECV = 2'd0,
        ST_EXEC = 2'd1,
        ST_RESP = 2'd2
    } lfci_state_e;

    typedef struct packed {
        logic valid;
        logic cmd_ready;
        logic go;
        logic avail;
        logic expect_more;
        logic rsv2;
        logic retry;
        logic rsv0;
    } lfci_sts_t;

    typedef struct packed {
        logic valid;
        logic rsv6;
        logic active;
        logic seized;
        logic seize;
        logic pending;
        logic req_use;
        logic estab;
    } lfci_acc_t;

    function automatic logic [15:0] sat16(input logic [31:0] v);
        return (v > 32'h0000_FFFF) ? 16'hFFFF : v[15:0];
    endfunction

endpackage

// File: rtl/lfci_locality.sv
module lfci_locality
    import lfci_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wbyte,
    output logic       active
);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
        end else if (wr_en) begin
            if (wbyte[ACC_REQ_BIT])
                active <= 1'b1;
            else if (wbyte[ACC_ACTIVE_BIT])
                active <= 1'b0;
        end
    end

    AST_GRANT_TAKES: assert property (@(posedge clk) disable iff (rst)
        wr_en && wbyte[ACC_REQ_BIT] |=> active); // R1
    AST_RELEASE_TAKES: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wbyte[ACC_REQ_BIT] && wbyte[ACC_ACTIVE_BIT] |=> !active); // R1

endmodule

// File: rtl/lfci_cmd_buf.sv
module lfci_cmd_buf
    import lfci_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic [7:0]       din,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte,
    output logic [CNT_W-1:0] cnt,
    output logic             expect_more
);

    localparam logic [31:0]      DEPTH32 = 32'(DEPTH);
    localparam logic [CNT_W-1:0] HDR_END = CNT_W'(HDR_BYTES);

    logic [7:0]       mem [DEPTH];
    logic [31:0]      hdr_len;
    logic [CNT_W-1:0] need;
    logic             accept;
    logic             in_len_field;

    always_comb begin
        need         = (hdr_len > DEPTH32) ? CNT_W'(DEPTH) : hdr_len[CNT_W-1:0];
        expect_more  = (cnt < HDR_END) || (cnt < need);
        accept       = push && expect_more;
        in_len_field = (cnt >= CNT_W'(2)) && (cnt <= CNT_W'(5));
        rd_byte      = mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt     <= '0;
            hdr_len <= '0;
        end else if (accept) begin
            cnt <= cnt + CNT_W'(1);
            if (in_len_field)
                hdr_len <= {hdr_len[23:0], din};
        end
    end

    always_ff @(posedge clk) begin
        if (accept && !clear)
            mem[cnt[IDX_W-1:0]] <= din;
    end

    AST_CMD_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH)); // R5
    AST_CMD_DROP: assert property (@(posedge clk) disable iff (rst)
        push && !expect_more && !clear |=> $stable(cnt)); // R5

endmodule

// File: rtl/lfci_rsp_buf.sv
module lfci_rsp_buf
    import lfci_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic [7:0]       din,
    input  logic             pop,
    input  logic             rewind,
    output logic [7:0]       rd_byte,
    output logic [CNT_W-1:0] wr_cnt,
    output logic [CNT_W-1:0] rd_ptr
);

    logic [7:0] mem [DEPTH];
    logic       can_push;
    logic       can_pop;

    always_comb begin
        can_push = push && (wr_cnt < CNT_W'(DEPTH));
        can_pop  = pop && (rd_ptr < wr_cnt);
        rd_byte  = mem[rd_ptr[IDX_W-1:0]];
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_cnt <= '0;
            rd_ptr <= '0;
        end else begin
            if (can_push)
                wr_cnt <= wr_cnt + CNT_W'(1);
            if (rewind)
                rd_ptr <= '0;
            else if (can_pop)
                rd_ptr <= rd_ptr + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (can_push && !clear)
            mem[wr_cnt[IDX_W-1:0]] <= din;
    end

    AST_RD_BEHIND_WR: assert property (@(posedge clk) disable iff (rst)
        rd_ptr <= wr_cnt); // R7
    AST_REWIND_ZERO: assert property (@(posedge clk) disable iff (rst)
        rewind && !clear |=> rd_ptr == '0); // R8

endmodule

// File: rtl/lfci_core.sv
module lfci_core
    import lfci_pkg::*;
#(
    parameter int          DEPTH     = 1024,
    parameter logic [31:0] CAP_VALUE = 32'h0000_0011,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_byte,
    input  logic [11:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             be_go,
    output logic [CNT_W-1:0] be_len,
    input  logic [IDX_W-1:0] be_cmd_idx,
    output logic [7:0]       be_cmd_byte,
    input  logic             be_rsp_valid,
    input  logic [7:0]       be_rsp_byte,
    input  logic             be_rsp_last
);

    lfci_state_e      state;
    logic             active;
    logic [31:0]      irq_en;
    logic [9:0]       waddr;
    logic [1:0]       lane;
    logic             wr_lane0, hit_acc, hit_ie, hit_cap, hit_sts, hit_data;
    logic             acc_wr, sts_wr, data_wr, data_rd, ie_wr;
    logic             abort, launch, retry, cmd_push, rsp_push, pop;
    logic [CNT_W-1:0] cmd_cnt, rsp_cnt, rsp_rd;
    logic             cmd_expect, avail;
    logic [7:0]       rsp_byte;
    logic [15:0]      burst;
    lfci_sts_t        sts;
    lfci_acc_t        acc;
    logic [31:0]      word;

    always_comb begin
        waddr    = bus_addr[11:2];
        lane     = bus_addr[1:0];
        hit_acc  = (waddr == WA_ACCESS);
        hit_ie   = (waddr == WA_IRQ_EN);
        hit_cap  = (waddr == WA_CAPS);
        hit_sts  = (waddr == WA_STATUS);
        hit_data = (waddr == WA_DATA);
        wr_lane0 = bus_sel && bus_wr && (lane == 2'd0);
        acc_wr   = wr_lane0 && hit_acc;
        sts_wr   = wr_lane0 && hit_sts && active;
        data_wr  = wr_lane0 && hit_data && active;
        ie_wr    = wr_lane0 && hit_ie && !bus_byte;
        data_rd  = bus_sel && !bus_wr && hit_data && (lane == 2'd0) && active;
        abort    = sts_wr && bus_wdata[STS_CMDRDY_BIT] && (state != ST_RECV);
        launch   = sts_wr && bus_wdata[STS_GO_BIT] && (state == ST_RECV)
                   && !cmd_expect && (cmd_cnt != '0);
        retry    = sts_wr && bus_wdata[STS_RETRY_BIT] && (state == ST_RESP);
        cmd_push = data_wr && (state == ST_RECV);
        rsp_push = be_rsp_valid && (state == ST_EXEC);
        avail    = (state == ST_RESP) && (rsp_rd < rsp_cnt);
        pop      = data_rd && avail;
    end

    lfci_locality u_loc (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (acc_wr),
        .wbyte  (bus_wdata[7:0]),
        .active (active)
    );

    lfci_cmd_buf #(.DEPTH(DEPTH)) u_cmd (
        .clk         (clk),
        .rst         (rst),
        .clear       (abort),
        .push        (cmd_push),
        .din         (bus_wdata[7:0]),
        .rd_idx      (be_cmd_idx),
        .rd_byte     (be_cmd_byte),
        .cnt         (cmd_cnt),
        .expect_more (cmd_expect)
    );

    lfci_rsp_buf #(.DEPTH(DEPTH)) u_rsp (
        .clk     (clk),
        .rst     (rst),
        .clear   (abort),
        .push    (rsp_push),
        .din     (be_rsp_byte),
        .pop     (pop),
        .rewind  (retry),
        .rd_byte (rsp_byte),
        .wr_cnt  (rsp_cnt),
        .rd_ptr  (rsp_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_RECV;
            be_go  <= 1'b0;
            be_len <= '0;
            irq_en <= '0;
        end else begin
            be_go <= launch;
            if (launch)
                be_len <= cmd_cnt;
            if (ie_wr)
                irq_en <= bus_wdata;
            if (abort)
                state <= ST_RECV;
            else if (launch)
                state <= ST_EXEC;
            else if (rsp_push && be_rsp_last)
                state <= ST_RESP;
        end
    end

    always_comb begin
        unique case (state)
            ST_RECV: burst = sat16(32'(CNT_W'(DEPTH) - cmd_cnt));
            ST_RESP: burst = sat16(32'(rsp_cnt - rsp_rd));
            default: burst = 16'h0000;
        endcase

        sts             = '0;
        sts.valid       = 1'b1;
        sts.cmd_ready   = (state == ST_RECV);
        sts.avail       = avail;
        sts.expect_more = (state == ST_RECV) && cmd_expect;

        acc        = '0;
        acc.valid  = 1'b1;
        acc.active = active;

        word = 32'h0000_0000;
        if (hit_acc)
            word = {24'h0, acc};
        else if (hit_ie)
            word = irq_en;
        else if (hit_cap)
            word = CAP_VALUE;
        else if (hit_sts)
            word = active ? {8'h00, burst, sts} : 32'hFFFF_FFFF;
        else if (hit_data)
            word = active ? {24'h0, (avail ? rsp_byte : 8'hFF)} : 32'hFFFF_FFFF;

        bus_rdata = bus_byte ? {24'h0, word[8*lane +: 8]} : word;
    end

    AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        be_go |=> !be_go); // R6
    AST_GO_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
        be_go |-> state == ST_EXEC); // R6
    AST_ABORT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        abort |=> (state == ST_RECV) && (cmd_cnt == '0) && (rsp_cnt == '0)); // R9
    AST_NOLOC_DATA_IGNORED: assert property (@(posedge clk) disable iff (rst)
        bus_sel && bus_wr && hit_data && !active |=> $stable(cmd_cnt)); // R2
    AST_CAP_NOT_ONES: assert property (@(posedge clk) disable iff (rst)
        bus_sel && !bus_wr && hit_cap && !bus_byte |-> bus_rdata != 32'hFFFF_FFFF); // R10

endmodule

// File: tb/lfci_core_test.sv
module lfci_core_test;

    localparam int DEPTH = 1024;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;
    localparam logic [31:0] CAP = 32'h0000_0011;

    // {header length field, response byte count}
    localparam logic [31:0] VEC [4] = '{
        {16'd10, 16'd10},
        {16'd12, 16'd14},
        {16'd3,  16'd1},
        {16'd40, 16'd5}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_sel = 1'b0, bus_wr = 1'b0, bus_byte = 1'b0;
    logic [11:0]      bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic             be_go;
    logic [CNT_W-1:0] be_len;
    logic [IDX_W-1:0] be_cmd_idx = '0;
    logic [7:0]       be_cmd_byte;
    logic             be_rsp_valid = 1'b0, be_rsp_last = 1'b0;
    logic [7:0]       be_rsp_byte = '0;

    int total = 0;
    int bad   = 0;
    logic [31:0] v;

    always #5 clk = ~clk;

    lfci_core #(.DEPTH(DEPTH), .CAP_VALUE(CAP)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .be_go(be_go), .be_len(be_len),
        .be_cmd_idx(be_cmd_idx), .be_cmd_byte(be_cmd_byte),
        .be_rsp_valid(be_rsp_valid), .be_rsp_byte(be_rsp_byte),
        .be_rsp_last(be_rsp_last)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic byt);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_byte = byt;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic byt, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_byte = byt;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    function automatic logic [7:0] cbyte(input int k, input int lf, input int s);
        case (k)
            0: return 8'h80;
            1: return 8'h01;
            2: return 8'(lf >> 24);
            3: return 8'(lf >> 16);
            4: return 8'(lf >> 8);
            5: return 8'(lf);
            default: return 8'(k * 3 + s);
        endcase
    endfunction

    function automatic logic [7:0] rbyte(input int k, input int s);
        return 8'(8'hA0 + k + s * 16);
    endfunction

    function automatic logic [31:0] stsw(input int b, input logic [7:0] s);
        return {8'h00, 16'(b), s};
    endfunction

    task automatic send_bytes(input int lf, input int n, input int s);
        for (int k = 0; k < n; k++) wr(12'h024, {24'h0, cbyte(k, lf, s)}, 1'b1);
    endtask

    task automatic be_respond(input int n, input int s);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            be_rsp_valid = 1'b1; be_rsp_byte = rbyte(k, s); be_rsp_last = (k == n - 1);
            @(posedge clk); #1;
            be_rsp_valid = 1'b0; be_rsp_last = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        rd(12'h000, 1'b1, v); chk("R1 reset access", v, 32'h80);
        rd(12'h018, 1'b0, v); chk("R2 status no locality", v, 32'hFFFF_FFFF);
        rd(12'h024, 1'b1, v); chk("R2 data no locality", v, 32'hFF);
        wr(12'h024, 32'h55, 1'b1);
        wr(12'h000, 32'h02, 1'b1);
        rd(12'h000, 1'b1, v); chk("R1 granted", v, 32'hA0);
        rd(12'h018, 1'b0, v); chk("R2 byte ignored / R3 R4 idle status", v, stsw(DEPTH, 8'hC8));

        wr(12'h008, 32'h8000_0007, 1'b0);
        rd(12'h008, 1'b0, v); chk("R10 irq enable", v, 32'h8000_0007);
        rd(12'h014, 1'b0, v); chk("R10 capability", v, CAP);

        for (int i = 0; i < 4; i++) begin
            int lf, nr, nb;
            lf = int'(VEC[i][31:16]);
            nr = int'(VEC[i][15:0]);
            nb = (lf < 6) ? 6 : lf;
            for (int k = 0; k < nb; k++) begin
                if (k == nb - 1) begin
                    rd(12'h018, 1'b0, v); chk("R5 expect before last", v, stsw(DEPTH - k, 8'hC8));
                    if (i == 0) begin
                        wr(12'h018, 32'h20, 1'b1);
                        chk("R6 go while expecting ignored", {31'h0, be_go}, 32'h0);
                        rd(12'h018, 1'b0, v); chk("R6 still receiving", v, stsw(DEPTH - k, 8'hC8));
                    end
                end
                wr(12'h024, {24'h0, cbyte(k, lf, i)}, 1'b1);
            end
            rd(12'h018, 1'b0, v); chk("R5 expect cleared", v, stsw(DEPTH - nb, 8'hC0));
            wr(12'h018, 32'h20, 1'b1);
            chk("R6 go pulse", {31'h0, be_go}, 32'h1);
            chk("R6 be_len", 32'(be_len), 32'(nb));
            be_cmd_idx = IDX_W'(nb - 1); #1;
            chk("R5 stored last byte", {24'h0, be_cmd_byte}, {24'h0, cbyte(nb - 1, lf, i)});
            rd(12'h018, 1'b0, v); chk("R4 exec burst zero", v, stsw(0, 8'h80));
            be_respond(nr, i);
            rd(12'h018, 1'b0, v); chk("R7 data available", v, stsw(nr, 8'h90));
            for (int k = 0; k < nr; k++) begin
                rd(12'h024, 1'b1, v); chk("R7 response byte", v, {24'h0, rbyte(k, i)});
            end
            rd(12'h018, 1'b0, v); chk("R7 avail falls", v, stsw(0, 8'h80));
            wr(12'h018, 32'h40, 1'b1);
            rd(12'h018, 1'b0, v); chk("R9 back to receive", v, stsw(DEPTH, 8'hC8));
        end

        // R8 retry
        send_bytes(8, 8, 7);
        wr(12'h018, 32'h20, 1'b1);
        be_respond(4, 7);
        rd(12'h024, 1'b1, v); chk("R8 first read", v, {24'h0, rbyte(0, 7)});
        rd(12'h024, 1'b1, v); chk("R8 second read", v, {24'h0, rbyte(1, 7)});
        wr(12'h018, 32'h02, 1'b1);
        rd(12'h018, 1'b0, v); chk("R8 burst after retry", v, stsw(4, 8'h90));
        rd(12'h024, 1'b1, v); chk("R8 rewound byte", v, {24'h0, rbyte(0, 7)});
        wr(12'h018, 32'h40, 1'b1);

        // R9 abort while executing, late response dropped
        send_bytes(6, 6, 2);
        wr(12'h018, 32'h20, 1'b1);
        wr(12'h018, 32'h40, 1'b1);
        rd(12'h018, 1'b0, v); chk("R9 abort in exec", v, stsw(DEPTH, 8'hC8));
        be_respond(1, 2);
        rd(12'h018, 1'b0, v); chk("R9 late response ignored", v, stsw(DEPTH, 8'hC8));

        // R4 byte reads of burst count
        send_bytes(7, 3, 1);
        rd(12'h019, 1'b1, v); chk("R4 burst low byte", v, 32'hFD);
        rd(12'h01A, 1'b1, v); chk("R4 burst high byte", v, 32'h03);
        rd(12'h018, 1'b1, v); chk("R4 status byte unchanged", v, 32'hC8);
        rd(12'h018, 1'b0, v); chk("R4 burst unchanged", v, stsw(DEPTH - 3, 8'hC8));

        // R5 length beyond depth
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        wr(12'h000, 32'h02, 1'b1);
        send_bytes(2000, DEPTH + 6, 5);
        rd(12'h018, 1'b0, v); chk("R5 capped at depth", v, stsw(0, 8'hC0));
        wr(12'h018, 32'h20, 1'b1);
        chk("R6 be_len capped", 32'(be_len), 32'(DEPTH));
        wr(12'h018, 32'h40, 1'b1);

        // R1 release, R2 status write ignored
        wr(12'h000, 32'h20, 1'b1);
        rd(12'h000, 1'b1, v); chk("R1 released", v, 32'h80);
        wr(12'h018, 32'h20, 1'b1);
        chk("R2 go without locality", {31'h0, be_go}, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule